// File: doc/BRIEF.md
# Completion Queue with Mispredict Flush

An in-order completion queue records instructions as they are dispatched and holds them until they retire. Up to two instructions enter per clock at the tail, each carrying a flag that marks it as a speculative branch, and the queue hands back the entry index that each one was given. Execution units later mark entries finished by index, in any order. The head retires finished entries strictly in program order, up to two per clock.

When a speculative branch is found to have been predicted wrongly, the branch's entry index is presented on the mispredict input. Every entry younger than that branch is dropped in that same cycle, and the tail moves to the slot just after the branch. The branch and all older entries stay in the queue and retire as usual. Dispatch is refused in the cycle the mispredict is applied and is accepted again from the next cycle, so the corrected path fills the freed slots.

Top module: `cmpl_queue`

## Requirements
- R1: After reset the queue is empty: no retire is signalled, and an offer of two instructions is accepted at entry indices 0 and 1.
- R2: Accepted instructions take consecutive entries starting at the tail, in lane order, wrapping after entry DEPTH-1. Lane 0 gets the tail index. Lane 1 gets the next index when lane 0 is also offered, and the tail index otherwise.
- R3: An offer is accepted whole or not at all. `disp_ready` is low, and nothing is enqueued, when fewer entries are free than instructions are offered (depth 5).
- R4: An entry retires only once it has been marked finished. Retirement follows program order, so a finished entry waits behind an unfinished older one, and no entry retires twice.
- R5: At most two entries retire per cycle. Lane 1 of the retire port retires the entry after the head, and it does so only when the head entry retires in the same cycle and both entries are finished.
- R6: On a mispredict, every entry younger than the indicated branch is removed. In the cycle after the mispredict, the tail equals the entry just after the branch.
- R7: The mispredicted branch and the entries older than it are kept and retire in order with their branch flags. A retire in the mispredict cycle never goes past the branch.
- R8: Dispatch is refused in the cycle a mispredict is applied. It is accepted again from the next cycle.
- R9: A finish marking that targets an entry removed by a flush in the same cycle has no effect. A later instruction placed in that entry is not finished until it is marked again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Instructions offered this cycle, one bit per lane |
| disp_branch | input | 2 | Speculative-branch flag for each offered lane |
| disp_ready | output | 1 | The whole offer is accepted this cycle |
| disp_idx0 | output | IW | Entry index given to lane 0 |
| disp_idx1 | output | IW | Entry index given to lane 1 |
| fin_valid | input | 2 | Finish markings this cycle, one per lane |
| fin_idx0 | input | IW | Entry index finished by lane 0 |
| fin_idx1 | input | IW | Entry index finished by lane 1 |
| mp_valid | input | 1 | Mispredict applied this cycle |
| mp_idx | input | IW | Entry index of the mispredicted branch |
| ret_valid | output | 2 | Entries retiring this cycle (bit 0 is the head) |
| ret_idx0 | output | IW | Index of the head entry |
| ret_idx1 | output | IW | Index of the entry after the head |
| ret_branch | output | 2 | Branch flags of the retiring entries |

## Verification
In-order retirement is tried with finish markings that arrive youngest first, oldest first, and two at once. These cases separate a head that waits for its own finish from one that retires any finished entry, and they show when the second retire lane may join. Filling the queue and then offering two instructions, and then one, separates an all-or-nothing stall from a partial accept. Mispredicts are applied to a branch in the middle of the queue and to a branch at the head that is retiring in the same cycle. Together these show the tail repair, the dispatch block, the limit on retiring past the branch, and the ignoring of a finish marking aimed at a removed entry.

// File: rtl/cmpl_queue.sv
`timescale 1ns/1ps
module cmpl_queue #(
  parameter int DEPTH = 5,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    disp_valid,
  input  logic [1:0]    disp_branch,
  output logic          disp_ready,
  output logic [IW-1:0] disp_idx0,
  output logic [IW-1:0] disp_idx1,
  input  logic [1:0]    fin_valid,
  input  logic [IW-1:0] fin_idx0,
  input  logic [IW-1:0] fin_idx1,
  input  logic          mp_valid,
  input  logic [IW-1:0] mp_idx,
  output logic [1:0]    ret_valid,
  output logic [IW-1:0] ret_idx0,
  output logic [IW-1:0] ret_idx1,
  output logic [1:0]    ret_branch
);

  logic [IW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] done, brf;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [CW-1:0] age_of(input logic [IW-1:0] i, input logic [IW-1:0] h);
    return (i >= h) ? CW'(i - h) : CW'(DEPTH) + CW'(i) - CW'(h);
  endfunction

  logic [CW-1:0] offered, free_n, ret_n, mp_age;
  logic [IW-1:0] h1;
  logic          acc;

  assign offered    = CW'(disp_valid[0]) + CW'(disp_valid[1]);
  assign free_n     = CW'(DEPTH) - count;
  assign disp_ready = !mp_valid && (free_n >= offered);
  assign acc        = disp_ready && (disp_valid != 2'b00);
  assign disp_idx0  = tail;
  assign disp_idx1  = disp_valid[0] ? nxt(tail) : tail;

  assign h1     = nxt(head);
  assign mp_age = age_of(mp_idx, head);

  assign ret_valid[0] = (count != '0) && done[head];
  assign ret_valid[1] = ret_valid[0] && (count >= CW'(2)) && done[h1] &&
                        !(mp_valid && mp_age == '0);
  assign ret_n      = CW'(ret_valid[0]) + CW'(ret_valid[1]);
  assign ret_idx0   = head;
  assign ret_idx1   = h1;
  assign ret_branch = {brf[h1] & ret_valid[1], brf[head] & ret_valid[0]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [CW-1:0] ea;
    logic vld, flushed, hit, wr0, wr1, clr;
    assign ea      = age_of(IW'(g), head);
    assign vld     = ea < count;
    assign flushed = mp_valid && vld && (ea > mp_age);
    assign hit     = (fin_valid[0] && fin_idx0 == IW'(g)) ||
                     (fin_valid[1] && fin_idx1 == IW'(g));
    assign wr0     = acc && disp_valid[0] && disp_idx0 == IW'(g);
    assign wr1     = acc && disp_valid[1] && disp_idx1 == IW'(g);
    assign clr     = (ret_valid[0] && head == IW'(g)) ||
                     (ret_valid[1] && h1 == IW'(g)) || flushed;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done[g] <= 1'b0;
        brf[g]  <= 1'b0;
      end else begin
        if (clr)             done[g] <= 1'b0;
        else if (hit && vld) done[g] <= 1'b1;
        if (wr0)      brf[g] <= disp_branch[0];
        else if (wr1) brf[g] <= disp_branch[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (ret_n == CW'(1))      head <= h1;
      else if (ret_n == CW'(2)) head <= nxt(h1);
      if (mp_valid) begin
        tail  <= nxt(mp_idx);
        count <= mp_age + CW'(1) - ret_n;
      end else begin
        if (acc) tail <= (offered == CW'(2)) ? nxt(nxt(tail)) : nxt(tail);
        count <= count + (acc ? offered : '0) - ret_n;
      end
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_RET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[1] |-> ret_valid[0]); // R5
  AST_NO_RETIRE_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[0] |=> !(ret_valid[0] && ret_idx0 == $past(ret_idx0))); // R4
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid |=> tail == nxt($past(mp_idx))); // R6
  AST_NO_DISP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid |-> !disp_ready); // R8

endmodule

// File: tb/cmpl_queue_test.sv
`timescale 1ns/1ps
module cmpl_queue_test;
  localparam int IW = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] disp_valid = '0, disp_branch = '0, fin_valid = '0;
  logic [IW-1:0] fin_idx0 = '0, fin_idx1 = '0, mp_idx = '0;
  logic mp_valid = 1'b0;
  logic disp_ready;
  logic [IW-1:0] disp_idx0, disp_idx1, ret_idx0, ret_idx1;
  logic [1:0] ret_valid, ret_branch;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cmpl_queue uut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic idle();
    disp_valid = '0; disp_branch = '0; fin_valid = '0; mp_valid = 1'b0;
  endtask

  task automatic do_reset();
    idle(); rst_n = 1'b0; step(); step(); rst_n = 1'b1; #1;
  endtask

  task automatic disp(input logic [1:0] v, input logic [1:0] b);
    disp_valid = v; disp_branch = b; step(); idle();
  endtask

  task automatic fin(input logic [1:0] v, input int a, input int b);
    fin_valid = v; fin_idx0 = IW'(a); fin_idx1 = IW'(b); step(); idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ret_valid", ret_valid, 0);
    disp_valid = 2'b11; #1;
    chk("R1 ready", disp_ready, 1);
    chk("R1 idx0", disp_idx0, 0);
    chk("R1 idx1", disp_idx1, 1);
    idle();
  endtask

  task automatic t_inorder();
    do_reset();
    disp(2'b11, 2'b00);
    fin(2'b01, 1, 0);
    chk("R4 young finished waits", ret_valid, 0);
    fin(2'b01, 0, 0);
    chk("R5 dual retire", ret_valid, 3);
    chk("R5 idx0", ret_idx0, 0);
    chk("R5 idx1", ret_idx1, 1);
    step();
    chk("R4 no re-retire", ret_valid, 0);
    disp_valid = 2'b10; #1;
    chk("R2 lane1 alone at tail", disp_idx1, 2);
    step(); idle();
    disp(2'b01, 2'b00);
    fin(2'b01, 2, 0);
    chk("R5 head only", ret_valid, 1);
  endtask

  task automatic t_full();
    do_reset();
    disp(2'b11, 2'b00);
    disp(2'b11, 2'b00);
    disp_valid = 2'b11; #1;
    chk("R3 stall two on one free", disp_ready, 0);
    step(); idle();
    disp_valid = 2'b01; #1;
    chk("R3 accept one", disp_ready, 1);
    chk("R2 idx four", disp_idx0, 4);
    step(); idle();
    disp_valid = 2'b01; #1;
    chk("R3 full stall", disp_ready, 0);
    idle();
    fin(2'b11, 0, 1);
    step();
    disp_valid = 2'b11; #1;
    chk("R2 wrap idx0", disp_idx0, 0);
    chk("R2 wrap idx1", disp_idx1, 1);
    idle();
  endtask

  task automatic t_flush_mid();
    do_reset();
    disp(2'b11, 2'b10);
    disp(2'b11, 2'b00);
    mp_valid = 1'b1; mp_idx = 3'd1; fin_valid = 2'b01; fin_idx0 = 3'd3;
    disp_valid = 2'b11; #1;
    chk("R8 blocked in flush", disp_ready, 0);
    step(); idle();
    disp_valid = 2'b11; #1;
    chk("R8 ready after flush", disp_ready, 1);
    chk("R6 tail after branch", disp_idx0, 2);
    step(); idle();
    fin(2'b11, 0, 1);
    chk("R7 older kept retire", ret_valid, 3);
    chk("R7 branch flags", ret_branch, 2);
    step();
    chk("R6 flushed not retired", ret_valid, 0);
    fin(2'b01, 2, 0);
    chk("R9 flushed finish ignored", ret_valid, 1);
    chk("R9 head idx", ret_idx0, 2);
  endtask

  task automatic t_flush_head();
    do_reset();
    disp(2'b11, 2'b01);
    fin(2'b11, 0, 1);
    chk("R5 pair ready", ret_valid, 3);
    mp_valid = 1'b1; mp_idx = 3'd0; #1;
    chk("R7 retire stops at branch", ret_valid, 1);
    chk("R7 branch flag", ret_branch, 1);
    step(); idle(); #1;
    chk("R6 queue empty", ret_valid, 0);
    disp_valid = 2'b01; #1;
    chk("R6 tail after head branch", disp_idx0, 1);
    idle();
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_inorder();
    t_full();
    t_flush_mid();
    t_flush_head();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule